// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command bytes that a host writes to a block-erasable flash array and keeps the mode state machine that decides what a read returns. The array is small and built from flops: `2**ADDR_W` bytes split into equal erase blocks of `2**BLK_W` bytes. Each bus write is either an opcode, taken while the controller sits in one of its read modes, or the operand that completes an armed command. Program, block erase and the lock commands all finish in the same cycle as their final write.

A read is combinational from the current address and the registered mode. Depending on the mode, it returns array contents, the status register, identifier words or a short query signature. Each erase block has its own lock bit, and one master lock guards those lock bits. The `hw_unlock` input overrides both kinds of lock. A command that fails sets sticky error bits in the status register, and these stay set until a clear command or a newly started operation removes them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write in any read mode (array, identifier, query, status) moves the controller to a new mode according to the opcode: FFh gives array read, 90h gives identifier read, 98h gives query read and 70h gives status read. B0h, D0h and every opcode that is not defined leave the mode and all state unchanged.
- R2: Opcode 50h, written in a read mode, ANDs the status register with C5h, which clears bits 5, 4, 3 and 1. It then selects status read.
- R3: Opcode 40h or 10h arms a program. The next write ANDs its data into the byte at its address, so a bit can only change from 1 to 0, and the controller then selects status read.
- R4: Opcode 20h arms a block erase. A following write of D0h sets every byte of the erase block that holds its address (address bits above BLK_W) to FFh and selects status read. A following write of any other data changes nothing and leaves the erase armed.
- R5: When a program or erase targets a block whose lock bit is set and `hw_unlock` is low, the array is left unchanged. A program then ORs 12h into status and an erase ORs 22h. When `hw_unlock` is high, the operation proceeds.
- R6: After opcode 60h, a second write of 01h sets the lock bit of the addressed block and D0h clears it. If the master lock is set and `hw_unlock` is low, the lock bit is left unchanged, and 01h ORs 12h into status while D0h ORs 22h. Either way the controller then selects status read.
- R7: After opcode 60h, a second write of F1h sets the master lock when `hw_unlock` is high and ORs 12h into status otherwise. 03h has no effect, and any other byte ORs 30h into status. The master lock never clears except at reset.
- R8: After reset the mode is array read, every array byte reads FFh, all lock bits and the master lock are clear, and status reads 80h. Bit 7 of status always reads 1, and bits 6, 3, 2 and 0 always read 0.
- R9: In identifier mode, with word address = byte address >> 1: word 0 reads 89h, word 1 reads 15h and word 3 reads the master lock in bit 0. Word 2 inside any erase block, meaning byte-in-block offset 4 or 5, reads that block's lock bit in bit 0. All other addresses read 00h.
- R10: Opcodes 40h, 10h, 20h and 60h AND the status register with C5h when they are accepted, before the armed operation runs.
- R11: In query mode, word 0 reads 89h, word 1 reads 15h, and words 10h, 11h and 12h read 51h, 52h and 59h. All other words read 00h. While a program, erase or lock command is armed, reads return the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address, used for both reads and writes |
| bus_wdata | input | 8 | Command or operand byte |
| hw_unlock | input | 1 | Hardware override of block and master locks |
| bus_rdata | output | 8 | Read data selected by the current mode |

## Verification
The checker takes `bus_we` to be a clean one-cycle strobe for each write, with address, data and `hw_unlock` held stable around the clock edge that samples them. It also takes the lock vector to be indexed by the address bits above BLK_W, so `bus_addr` must stay inside the array. The bench meets these conditions by changing every input on the falling edge, dropping `bus_we` just after the rising edge that consumes it, and using only addresses below `2**ADDR_W`. It also keeps `hw_unlock` low except in the cycles that test the override, so every lock check runs both with and without it.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
    typedef enum logic [2:0] {
        M_ARRAY, M_IDENT, M_QUERY, M_STATUS, M_PROG, M_ERASE, M_LOCK
    } mode_e;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_READ_IDENT = 8'h90;
    localparam logic [7:0] OP_READ_QUERY = 8'h98;
    localparam logic [7:0] OP_READ_STAT  = 8'h70;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;
    localparam logic [7:0] OP_PROG_A     = 8'h40;
    localparam logic [7:0] OP_PROG_B     = 8'h10;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_LOCK       = 8'h60;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_SUSPEND    = 8'hB0;
    localparam logic [7:0] LK_SET_BLK    = 8'h01;
    localparam logic [7:0] LK_SET_MASTER = 8'hF1;
    localparam logic [7:0] LK_NOP        = 8'h03;

    localparam logic [7:0] ST_RESET      = 8'h80;
    localparam logic [7:0] ST_KEEP_MASK  = 8'hC5;
    localparam logic [7:0] ERR_PROG      = 8'h12;
    localparam logic [7:0] ERR_ERASE     = 8'h22;
    localparam logic [7:0] ERR_SEQ       = 8'h30;

    localparam logic [7:0] ID_MAKER      = 8'h89;
    localparam logic [7:0] ID_DEVICE     = 8'h15;
endpackage

// File: rtl/fcc_array.sv
`timescale 1ns/1ps
module fcc_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BI_W  = ADDR_W - BLK_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [ADDR_W-1:0] ia;
            ia = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (erase_en && ia[ADDR_W-1:BLK_W] == addr[ADDR_W-1:BLK_W])
                mem_d[i] = 8'hFF;
            if (prog_en && ia == addr)
                mem_d[i] = mem_q[i] & wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[addr];

    logic [BI_W-1:0] unused_bi;
    assign unused_bi = '0;
endmodule

// File: rtl/fcc_locks.sv
`timescale 1ns/1ps
module fcc_locks #(
    parameter int BI_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_blk,
    input  logic                  clr_blk,
    input  logic                  set_master,
    input  logic [BI_W-1:0]       blk_idx,
    output logic [(1<<BI_W)-1:0]  lock_q,
    output logic                  master_q
);
    localparam int NUM_BLK = 1 << BI_W;

    logic [NUM_BLK-1:0] lock_d;
    logic               master_d;

    always_comb begin
        lock_d   = lock_q;
        master_d = master_q | set_master;
        if (set_blk) lock_d[blk_idx] = 1'b1;
        if (clr_blk) lock_d[blk_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q   <= '0;
            master_q <= 1'b0;
        end else begin
            lock_q   <= lock_d;
            master_q <= master_d;
        end
    end
endmodule

// File: rtl/fcc_rdmux.sv
`timescale 1ns/1ps
module fcc_rdmux
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input  mode_e                          mode,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     status,
    input  logic [7:0]                     arr_data,
    input  logic [(1<<(ADDR_W-BLK_W))-1:0] lock_vec,
    input  logic                           master,
    output logic [7:0]                     rdata
);
    localparam int WA_W = ADDR_W - 1;
    localparam int BW_W = BLK_W - 1;

    logic [WA_W-1:0] word;
    logic [BW_W-1:0] blk_word;
    logic            blk_lock;

    assign word     = addr[ADDR_W-1:1];
    assign blk_word = addr[BLK_W-1:1];
    assign blk_lock = lock_vec[addr[ADDR_W-1:BLK_W]];

    always_comb begin
        rdata = 8'h00;
        case (mode)
            M_ARRAY: rdata = arr_data;
            M_IDENT: begin
                if (word == WA_W'(0))           rdata = ID_MAKER;
                else if (word == WA_W'(1))      rdata = ID_DEVICE;
                else if (word == WA_W'(3))      rdata = {7'd0, master};
                else if (blk_word == BW_W'(2))  rdata = {7'd0, blk_lock};
            end
            M_QUERY: begin
                if (word == WA_W'(0))           rdata = ID_MAKER;
                else if (word == WA_W'(1))      rdata = ID_DEVICE;
                else if (word == WA_W'(16))     rdata = 8'h51;
                else if (word == WA_W'(17))     rdata = 8'h52;
                else if (word == WA_W'(18))     rdata = 8'h59;
            end
            default: rdata = status;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              hw_unlock,
    output logic [7:0]        bus_rdata
);
    localparam int BI_W    = ADDR_W - BLK_W;
    localparam int NUM_BLK = 1 << BI_W;

    typedef struct packed {
        mode_e      mode;
        logic [7:0] status;
    } ctl_t;

    ctl_t st_d, st_q;

    logic               prog_en, erase_en, set_blk, clr_blk, set_master;
    logic [NUM_BLK-1:0] lock_vec;
    logic               master_lk;
    logic [BI_W-1:0]    blk_idx;
    logic               blk_guarded;
    logic               lock_guarded;
    logic [7:0]         arr_data;

    assign blk_idx      = bus_addr[ADDR_W-1:BLK_W];
    assign blk_guarded  = lock_vec[blk_idx] && !hw_unlock;
    assign lock_guarded = master_lk && !hw_unlock;

    always_comb begin
        st_d       = st_q;
        prog_en    = 1'b0;
        erase_en   = 1'b0;
        set_blk    = 1'b0;
        clr_blk    = 1'b0;
        set_master = 1'b0;
        if (bus_we) begin
            case (st_q.mode)
                M_PROG: begin
                    if (blk_guarded) st_d.status = st_q.status | ERR_PROG;
                    else             prog_en = 1'b1;
                    st_d.mode = M_STATUS;
                end
                M_ERASE: begin
                    if (bus_wdata == OP_CONFIRM) begin
                        if (blk_guarded) st_d.status = st_q.status | ERR_ERASE;
                        else             erase_en = 1'b1;
                        st_d.mode = M_STATUS;
                    end
                end
                M_LOCK: begin
                    case (bus_wdata)
                        LK_SET_MASTER: begin
                            if (hw_unlock) set_master = 1'b1;
                            else           st_d.status = st_q.status | ERR_PROG;
                        end
                        LK_SET_BLK: begin
                            if (lock_guarded) st_d.status = st_q.status | ERR_PROG;
                            else              set_blk = 1'b1;
                        end
                        OP_CONFIRM: begin
                            if (lock_guarded) st_d.status = st_q.status | ERR_ERASE;
                            else              clr_blk = 1'b1;
                        end
                        LK_NOP: ;
                        default: st_d.status = st_q.status | ERR_SEQ;
                    endcase
                    st_d.mode = M_STATUS;
                end
                default: begin
                    case (bus_wdata)
                        OP_READ_ARRAY: st_d.mode = M_ARRAY;
                        OP_READ_IDENT: st_d.mode = M_IDENT;
                        OP_READ_QUERY: st_d.mode = M_QUERY;
                        OP_READ_STAT:  st_d.mode = M_STATUS;
                        OP_CLR_STAT: begin
                            st_d.mode   = M_STATUS;
                            st_d.status = st_q.status & ST_KEEP_MASK;
                        end
                        OP_PROG_A, OP_PROG_B: begin
                            st_d.mode   = M_PROG;
                            st_d.status = st_q.status & ST_KEEP_MASK;
                        end
                        OP_ERASE: begin
                            st_d.mode   = M_ERASE;
                            st_d.status = st_q.status & ST_KEEP_MASK;
                        end
                        OP_LOCK: begin
                            st_d.mode   = M_LOCK;
                            st_d.status = st_q.status & ST_KEEP_MASK;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= M_ARRAY;
            st_q.status <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    fcc_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rd_data  (arr_data)
    );

    fcc_locks #(.BI_W(BI_W)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_blk    (set_blk),
        .clr_blk    (clr_blk),
        .set_master (set_master),
        .blk_idx    (blk_idx),
        .lock_q     (lock_vec),
        .master_q   (master_lk)
    );

    fcc_rdmux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_rdmux (
        .mode     (st_q.mode),
        .addr     (bus_addr),
        .status   (st_q.status),
        .arr_data (arr_data),
        .lock_vec (lock_vec),
        .master   (master_lk),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_we,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [7:0]                     bus_wdata,
    input logic                           hw_unlock,
    input mode_e                          mode_q,
    input logic [7:0]                     status_q,
    input logic                           master_q,
    input logic [(1<<(ADDR_W-BLK_W))-1:0] lock_q
);
    logic in_read;
    logic tgt_lock;
    assign in_read  = (mode_q == M_ARRAY) || (mode_q == M_IDENT) ||
                      (mode_q == M_QUERY) || (mode_q == M_STATUS);
    assign tgt_lock = lock_q[bus_addr[ADDR_W-1:BLK_W]];

    assert_status_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[7] && ((status_q & 8'h4D) == 8'h00));

    assert_ff_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_read && bus_we && bus_wdata == 8'hFF |=> mode_q == M_ARRAY);

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_read && bus_we && bus_wdata == 8'h50 |=>
        ((status_q & 8'h3A) == 8'h00) && mode_q == M_STATUS);

    assert_prog_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == M_PROG && bus_we |=> mode_q == M_STATUS);

    assert_erase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == M_ERASE && bus_we && bus_wdata != 8'hD0 |=> mode_q == M_ERASE);

    assert_prog_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == M_PROG && bus_we && tgt_lock && !hw_unlock |=>
        status_q[4] && status_q[1]);

    assert_master_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(master_q));
endmodule

bind flash_cmd_ctrl fcc_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_unlock (hw_unlock),
    .mode_q    (st_q.mode),
    .status_q  (st_q.status),
    .master_q  (master_lk),
    .lock_q    (lock_vec)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              hw_unlock = 1'b0;
    logic [7:0]        bus_rdata;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic chk_req = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hw_unlock(hw_unlock), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic hw);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        hw_unlock = hw;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
        hw_unlock = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        chk_req = 1'b1;
        @(posedge clk);
        #1 chk_req = 1'b0;
    endtask

    // monitor: samples 3 ns after the falling edge, ahead of the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (chk_req && exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: addr %02h got %02h expected %02h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 reset state
        rd(8'h05, 8'hFF, "R8 array erased");
        rd(8'hC3, 8'hFF, "R8 array erased top");
        wr(8'h00, 8'h70, 1'b0);
        rd(8'h11, 8'h80, "R8 status ready");
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h00, 8'h89, "R9 maker");
        rd(8'h02, 8'h15, "R9 device");
        rd(8'h44, 8'h00, "R8 lock clear");
        rd(8'h06, 8'h00, "R8 master clear");
        rd(8'h08, 8'h00, "R9 other word");

        // R3 program
        wr(8'h00, 8'h40, 1'b0);
        wr(8'h05, 8'hA5, 1'b0);
        rd(8'h05, 8'h80, "R3 status after program");
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h05, 8'hA5, "R3 programmed");
        wr(8'h00, 8'h10, 1'b0);
        wr(8'h05, 8'h0F, 1'b0);
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h05, 8'h05, "R3 and only clears");
        wr(8'h00, 8'h40, 1'b0);
        wr(8'h45, 8'h3C, 1'b0);

        // R4 erase
        wr(8'h00, 8'h20, 1'b0);
        wr(8'h05, 8'h00, 1'b0);
        rd(8'h05, 8'h80, "R11 armed erase reads status");
        wr(8'h07, 8'hD0, 1'b0);
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h05, 8'hFF, "R4 block erased");
        rd(8'h45, 8'h3C, "R4 other block kept");

        // R6 lock block 1
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h45, 8'h01, 1'b0);
        rd(8'h00, 8'h80, "R6 lock set ok");
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h44, 8'h01, "R9 block1 lock bit");
        rd(8'h04, 8'h00, "R9 block0 lock bit");

        // R5 locked program / erase
        wr(8'h00, 8'h40, 1'b0);
        wr(8'h45, 8'h00, 1'b0);
        rd(8'h00, 8'h92, "R5 program lock error");
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h45, 8'h3C, "R5 locked byte unchanged");
        wr(8'h00, 8'h50, 1'b0);
        rd(8'h00, 8'h80, "R2 clear status");
        wr(8'h00, 8'h20, 1'b0);
        wr(8'h45, 8'hD0, 1'b0);
        rd(8'h00, 8'hA2, "R5 erase lock error");
        wr(8'h00, 8'h40, 1'b0);
        rd(8'h00, 8'h80, "R10 program start clears errors");
        wr(8'h45, 8'h0F, 1'b1);
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h45, 8'h0C, "R5 hw unlock override");

        // R7 master lock
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h00, 8'hF1, 1'b0);
        rd(8'h00, 8'h92, "R7 master needs hw unlock");
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h06, 8'h00, "R7 master still clear");
        wr(8'h00, 8'h60, 1'b0);
        rd(8'h00, 8'h80, "R10 lock start clears errors");
        wr(8'h00, 8'hF1, 1'b1);
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h06, 8'h01, "R9 master bit set");
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h45, 8'hD0, 1'b0);
        rd(8'h00, 8'hA2, "R6 clear blocked by master");
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h85, 8'h01, 1'b0);
        rd(8'h00, 8'h92, "R6 set blocked by master");
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h84, 8'h00, "R6 block2 unchanged");
        rd(8'h44, 8'h01, "R6 block1 unchanged");
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h45, 8'hD0, 1'b1);
        wr(8'h00, 8'h90, 1'b0);
        rd(8'h44, 8'h00, "R6 clear with hw unlock");
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h00, 8'h03, 1'b0);
        rd(8'h00, 8'h80, "R7 03h ignored");
        wr(8'h00, 8'h60, 1'b0);
        wr(8'h00, 8'h77, 1'b0);
        rd(8'h00, 8'hB0, "R7 bad lock byte");

        // R1 mode selection and ignored opcodes
        wr(8'h00, 8'h90, 1'b0);
        wr(8'h00, 8'h33, 1'b0);
        rd(8'h00, 8'h89, "R1 unknown opcode keeps mode");
        wr(8'h00, 8'hB0, 1'b0);
        rd(8'h02, 8'h15, "R1 B0h no effect");
        wr(8'h00, 8'h98, 1'b0);
        rd(8'h20, 8'h51, "R11 query Q");
        rd(8'h22, 8'h52, "R11 query R");
        rd(8'h24, 8'h59, "R11 query Y");
        rd(8'h26, 8'h00, "R11 query other");
        wr(8'h00, 8'hD0, 1'b0);
        rd(8'h00, 8'h89, "R1 D0h no effect");
        wr(8'h00, 8'h70, 1'b0);
        rd(8'h00, 8'hB0, "R1 status mode, errors kept");
        wr(8'h00, 8'hFF, 1'b0);
        rd(8'h45, 8'h0C, "R1 back to array");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule